// File: doc/BRIEF.md
# Fast Ethernet 4B/5B Transmit Framing Encoder

This block sits between the MAC transmit nibble interface and the physical coding path of a 100 Mb/s twisted-pair link. On every nibble clock it samples a transmit-enable qualifier and a 4-bit data nibble. It produces exactly one registered 5-bit code-group per clock.

While no frame is in progress it sends the Idle code-group, so the line never goes quiet. When a frame begins, the first two preamble nibbles are replaced by the start delimiter pair /J/ /K/. Every later nibble goes through the 4B/5B data table. When the enable drops after the last nibble, the block appends the end delimiter pair /T/ /R/ and then returns to Idle.

Scrambling, serialization, line coding, receive decoding and collision handling are handled elsewhere.

Top module: `fetx_encoder`

## Requirements
- R1: While rst_ni is low, code_o is Idle (11111) and code_valid_o is 0. From the first rising edge after reset is released, code_valid_o is 1 and stays 1, and a new code-group is presented on every clock.
- R2: A data nibble maps to these code-groups: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R3: When no frame is in progress, code_o is Idle (11111) on every clock.
- R4: The first nibble of a frame is sent as /J/ (11000) and the second as /K/ (10001). Their data values are discarded.
- R5: The first clock on which tx_en_i is sampled low after a frame produces /T/ (01101). The next clock produces /R/ (00111), and the clock after that produces Idle.
- R6: The third and every later nibble of a frame, including the remaining preamble nibbles, is encoded through the R2 table.
- R7: A frame of only one nibble still produces /J/, /K/, /T/ and /R/ in that order. A frame of two nibbles produces the same sequence.
- R8: A frame start is recognised only while the encoder is idle. Nibbles sampled while a delimiter is being completed (during /K/ of a one-nibble frame, /T/ or /R/) are discarded, and no new frame starts from them.
- R9: The code-group for inputs sampled at a rising edge appears on code_o directly after that same edge, which is a latency of one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Transmit nibble clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Frame qualifier from the MAC |
| txd_i | input | 4 | Transmit nibble from the MAC |
| code_o | output | 5 | Registered 5-bit code-group |
| code_valid_o | output | 1 | High on every clock after reset |

## Verification
Each code-group is due exactly one clock after the edge that sampled its nibble and enable. /J/ follows that sampling edge directly, /K/ comes one clock later, /T/ appears one clock after the first low enable, and /R/ one clock after /T/. The bench drives the inputs on the falling edge. It advances a reference model that it builds from the requirements at the same rising edge as the design. It then compares the output at the next falling edge, so each comparison lands on the single cycle in which the result is due. Directed frames of one, two and three nibbles, together with restarts that arrive during the end delimiter, pin down the cycles of the delimiters. Random frames with random gaps cover the data table.

// File: rtl/fetx_pkg.sv
package fetx_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CG_W  = 5;

  localparam logic [CG_W-1:0] CG_IDLE = 5'b11111;
  localparam logic [CG_W-1:0] CG_J    = 5'b11000;
  localparam logic [CG_W-1:0] CG_K    = 5'b10001;
  localparam logic [CG_W-1:0] CG_T    = 5'b01101;
  localparam logic [CG_W-1:0] CG_R    = 5'b00111;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SSD_J = 3'd1,
    ST_SSD_K = 3'd2,
    ST_DATA  = 3'd3,
    ST_ESD_T = 3'd4,
    ST_ESD_R = 3'd5
  } fetx_state_e;
endpackage

// File: rtl/fetx_nibble_map.sv
module fetx_nibble_map
  import fetx_pkg::*;
(
  input  logic [NIB_W-1:0] nib_i,
  output logic [CG_W-1:0]  cg_o
);
  always_comb begin
    unique case (nib_i)
      4'h0: cg_o = 5'b11110;
      4'h1: cg_o = 5'b01001;
      4'h2: cg_o = 5'b10100;
      4'h3: cg_o = 5'b10101;
      4'h4: cg_o = 5'b01010;
      4'h5: cg_o = 5'b01011;
      4'h6: cg_o = 5'b01110;
      4'h7: cg_o = 5'b01111;
      4'h8: cg_o = 5'b10010;
      4'h9: cg_o = 5'b10011;
      4'hA: cg_o = 5'b10110;
      4'hB: cg_o = 5'b10111;
      4'hC: cg_o = 5'b11010;
      4'hD: cg_o = 5'b11011;
      4'hE: cg_o = 5'b11100;
      default: cg_o = 5'b11101;
    endcase
  end
endmodule

// File: rtl/fetx_frame_fsm.sv
module fetx_frame_fsm
  import fetx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  output fetx_state_e state_d_o
);
  fetx_state_e state_q, state_d;
  logic        short_q, short_d;

  // state_q names the group currently driven on the output
  always_comb begin
    state_d = state_q;
    short_d = short_q;
    unique case (state_q)
      ST_IDLE: begin
        short_d = 1'b0;
        if (tx_en_i) state_d = ST_SSD_J;
      end
      ST_SSD_J: begin
        short_d = ~tx_en_i;
        state_d = ST_SSD_K;
      end
      ST_SSD_K: state_d = (tx_en_i && !short_q) ? ST_DATA : ST_ESD_T;
      ST_DATA:  state_d = tx_en_i ? ST_DATA : ST_ESD_T;
      ST_ESD_T: state_d = ST_ESD_R;
      ST_ESD_R: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      short_q <= short_d;
    end
  end

  assign state_d_o = state_d;

  AST_SHORT_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SSD_K && short_q) |=> (state_q == ST_ESD_T)); // R7
  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SSD_J) |-> ($past(state_q) == ST_IDLE)); // R8
endmodule

// File: rtl/fetx_cg_select.sv
module fetx_cg_select
  import fetx_pkg::*;
(
  input  fetx_state_e     state_i,
  input  logic [CG_W-1:0] data_cg_i,
  output logic [CG_W-1:0] cg_o
);
  always_comb begin
    unique case (state_i)
      ST_SSD_J: cg_o = CG_J;
      ST_SSD_K: cg_o = CG_K;
      ST_DATA:  cg_o = data_cg_i;
      ST_ESD_T: cg_o = CG_T;
      ST_ESD_R: cg_o = CG_R;
      default:  cg_o = CG_IDLE;
    endcase
  end
endmodule

// File: rtl/fetx_encoder.sv
module fetx_encoder
  import fetx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic [CG_W-1:0]  code_o,
  output logic             code_valid_o
);
  fetx_state_e     state_d;
  logic [CG_W-1:0] data_cg, cg_d;
  logic [CG_W-1:0] code_q;
  logic            valid_q;

  fetx_frame_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .state_d_o (state_d)
  );

  fetx_nibble_map u_map (
    .nib_i (txd_i),
    .cg_o  (data_cg)
  );

  fetx_cg_select u_sel (
    .state_i   (state_d),
    .data_cg_i (data_cg),
    .cg_o      (cg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= CG_IDLE;
      valid_q <= 1'b0;
    end else begin
      code_q  <= cg_d;
      valid_q <= 1'b1;
    end
  end

  assign code_o       = code_q;
  assign code_valid_o = valid_q;

  AST_VALID_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_valid_o |=> code_valid_o); // R1
  AST_J_THEN_K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_J) |=> (code_o == CG_K)); // R4
  AST_T_THEN_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_T) |=> (code_o == CG_R)); // R5
  AST_R_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_R) |=> (code_o == CG_IDLE)); // R5
  AST_K_ENDS_OR_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o == CG_K) |=> (code_o != CG_IDLE && code_o != CG_J)); // R7
endmodule

// File: tb/fetx_encoder_test.sv
`timescale 1ns/1ps
module fetx_encoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] code;
  logic       valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int m_st = 0;
  bit m_short = 1'b0;

  always #2.5 clk = ~clk;

  fetx_encoder uut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .txd_i(txd),
    .code_o(code), .code_valid_o(valid)
  );

  function automatic logic [4:0] ref_map(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic string tag_of(input int st);
    case (st)
      0: return "R3";
      1, 2: return "R4";
      3: return "R2";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: code actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one nibble, advance model, check after the sampling edge
  task automatic step(input bit en, input logic [3:0] d, input string tag);
    logic [4:0] e;
    int nst;
    tx_en = en;
    txd   = d;
    case (m_st)
      0: begin nst = en ? 1 : 0; m_short = 1'b0; end
      1: begin nst = 2; m_short = ~en; end
      2: nst = (en && !m_short) ? 3 : 4;
      3: nst = en ? 3 : 4;
      4: nst = 5;
      default: nst = 0;
    endcase
    m_st = nst;
    case (nst)
      0: e = 5'b11111;
      1: e = 5'b11000;
      2: e = 5'b10001;
      3: e = ref_map(d);
      4: e = 5'b01101;
      default: e = 5'b00111;
    endcase
    @(posedge clk);
    @(negedge clk);
    check((tag == "") ? tag_of(nst) : tag, code, e);
    checks++;
    if (valid !== 1'b1) begin
      fails++;
      $display("FAIL R1: valid actual=%b expected=1", valid);
    end
  endtask

  task automatic frame(input int len, input int gap, input string tag);
    for (int i = 0; i < len; i++) step(1'b1, 4'($urandom_range(15)), tag);
    for (int i = 0; i < gap; i++) step(1'b0, 4'($urandom_range(15)), tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    @(negedge clk);
    checks++;
    if (code !== 5'b11111 || valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset code=%b valid=%b expected=11111/0", code, valid);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, 4'h5, "R3");
    // R9: J right after the first sampling edge
    step(1'b1, 4'h5, "R9");
    step(1'b1, 4'h5, "R4");
    // R6: remaining preamble encoded as data
    for (int i = 0; i < 13; i++) step(1'b1, 4'h5, "R6");
    step(1'b1, 4'hD, "R6");
    // R2: every table entry
    for (int n = 0; n < 16; n++) step(1'b1, 4'(n), "R2");
    step(1'b0, 4'h0, "R5");
    step(1'b0, 4'h0, "R5");
    step(1'b0, 4'h0, "R3");
    // R7: one- and two-nibble frames
    step(1'b1, 4'h3, "R7");
    step(1'b0, 4'h3, "R7");
    step(1'b0, 4'h3, "R7");
    step(1'b0, 4'h3, "R7");
    step(1'b0, 4'h3, "R7");
    step(1'b1, 4'h1, "R7");
    step(1'b1, 4'h2, "R7");
    step(1'b0, 4'h0, "R7");
    step(1'b0, 4'h0, "R7");
    step(1'b0, 4'h0, "R7");
    // R8: enable raised during delimiters is discarded
    step(1'b1, 4'h7, "R8");
    step(1'b0, 4'h7, "R8");
    step(1'b1, 4'h7, "R8");
    step(1'b1, 4'h7, "R8");
    step(1'b1, 4'h7, "R8");
    step(1'b1, 4'h9, "R8");
    step(1'b1, 4'h9, "R8");
    step(1'b0, 4'h9, "R8");
    step(1'b1, 4'h9, "R8");
    step(1'b1, 4'h9, "R8");
    step(1'b0, 4'h0, "R8");
    for (int i = 0; i < 4; i++) step(1'b0, 4'h0, "");
    for (int f = 0; f < 300; f++)
      frame(1 + int'($urandom_range(39)), 1 + int'($urandom_range(5)), "");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule